// File: doc/BRIEF.md
# Paged Memory Map Translator

This block sits between the processor's 16-bit memory address register and a core memory of 256K words. Each request carries a virtual word address; the upper seven bits pick one of 128 virtual pages of 512 words, and a small map RAM turns that page into a 9-bit physical page number. The number is made of a 2-bit bank select and a 7-bit page within the bank. The 9-bit word offset passes through unchanged, so the result is an 18-bit physical address.

Each map entry also carries three control flags. Write-protect marks a page as read-only. Not-present marks a page that is not allocated to the running user. Foreign-lock marks a page that another processor owns. The flags are copied into a status register in the cycle after the request, so the sequencer can act before core data returns. A write to a write-protected page is stopped, and so is any access to a foreign-locked page; each such request raises a one-cycle abort pulse. An access to a not-present page is stopped and sets a sticky fault flag, which records the virtual page.

The map is reloaded one entry at a time through a load port whenever a new user starts. A bypass bit sends the raw address to memory, so core accesses can go on during the reload. The bypass bit is set out of reset, which avoids a bootstrap problem at start-up.

Top module: `pmap_xlate`

## Requirements
- R1: After reset `mem_strobe`, `mem_write`, `abort`, `stat_flags` and `fault` are all 0, and the bypass bit is 1.
- R2: With bypass off, a request at a clock edge drives `mem_paddr = {entry[8:0], req_vaddr[8:0]}` after that edge, where `entry = map[req_vaddr[15:9]]`. Here `entry[6:0]` is the page within the bank and `entry[8:7]` is the bank select. `mem_write` equals `req_write` and is only ever high together with `mem_strobe`.
- R3: `map_we` writes `map_wdata` into entry `map_idx` at the clock edge. A request in that same cycle to that same page still uses the previous contents of the entry.
- R4: On every request, `stat_flags` is loaded with the entry flags: bit 0 is write-protect (`entry[9]`), bit 1 is not-present (`entry[10]`) and bit 2 is foreign-lock (`entry[11]`). Without a request, `stat_flags` holds its value.
- R5: A write to a write-protect page gives no `mem_strobe` and an `abort` pulse. A read of such a page gives a normal strobe and no abort.
- R6: Any access, read or write, to a foreign-lock page gives no `mem_strobe` and an `abort` pulse.
- R7: An access to a not-present page gives no `mem_strobe` and sets `fault`. `fault` stays set until `fault_clr` is asserted, and a new fault in the clearing cycle wins. `fault_vpn` captures the page number only when `fault` is clear or is being cleared.
- R8: While bypass is on, `mem_paddr = {2'b00, req_vaddr}`, `stat_flags` loads 0, and no request is aborted or faulted.
- R9: `byp_we` loads `byp_val` into the bypass bit at the clock edge. The new setting applies to requests from the next cycle on.
- R10: `abort` and `mem_strobe` are single-cycle outputs. They are low in any cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Write one map entry |
| map_idx | input | 7 | Virtual page to load |
| map_wdata | input | 12 | Entry value: {lock, not-present, write-protect, bank, page} |
| byp_we | input | 1 | Load the bypass bit |
| byp_val | input | 1 | New bypass value |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 16 | Virtual word address |
| fault_clr | input | 1 | Clear the fault flag |
| mem_strobe | output | 1 | Start core access |
| mem_write | output | 1 | Core access is a write |
| mem_paddr | output | 18 | Physical word address |
| stat_flags | output | 3 | Latched flags {lock, not-present, write-protect} |
| abort | output | 1 | One-cycle abort pulse |
| fault | output | 1 | Sticky not-present fault |
| fault_vpn | output | 7 | Page of the captured fault |

## Verification
The assertions assume that the flags seen by a request come from an entry that was loaded before the request. For this reason the bench fills all 128 entries while bypass is on, and only then turns bypass off. They also assume that `fault_clr` is a level input that may coincide with a new fault; the stimulus produces that case on purpose. A random phase mixes requests, reloads of entries during traffic, bypass toggles and clears, and every value stays within the declared port widths.

// File: rtl/pmap_xlate.sv
module pmap_xlate #(
  parameter int VA_W   = 16,
  parameter int OFS_W  = 9,
  parameter int PPN_W  = 9,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int ENT_W = PPN_W + 3,
  localparam int PA_W  = PPN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_we,
  input  logic [VPN_W-1:0] map_idx,
  input  logic [ENT_W-1:0] map_wdata,
  input  logic             byp_we,
  input  logic             byp_val,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             fault_clr,
  output logic             mem_strobe,
  output logic             mem_write,
  output logic [PA_W-1:0]  mem_paddr,
  output logic [2:0]       stat_flags,
  output logic             abort,
  output logic             fault,
  output logic [VPN_W-1:0] fault_vpn
);
  localparam int PAGES = 1 << VPN_W;

  logic [ENT_W-1:0] map_mem [PAGES];
  logic             byp_q;

  always_ff @(posedge clk)
    if (map_we) map_mem[map_idx] <= map_wdata;

  logic [VPN_W-1:0] vpn;
  logic [ENT_W-1:0] ent;
  logic             f_wp, f_np, f_lk, stop, kill;
  logic [PA_W-1:0]  xaddr;

  assign vpn   = req_vaddr[VA_W-1:OFS_W];
  assign ent   = map_mem[vpn];
  assign f_wp  = ~byp_q & ent[PPN_W];
  assign f_np  = ~byp_q & ent[PPN_W+1];
  assign f_lk  = ~byp_q & ent[PPN_W+2];
  assign kill  = f_lk | (req_write & f_wp);
  assign stop  = kill | f_np;
  assign xaddr = byp_q ? {{(PA_W-VA_W){1'b0}}, req_vaddr}
                       : {ent[PPN_W-1:0], req_vaddr[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_q      <= 1'b1;
      mem_strobe <= 1'b0;
      mem_write  <= 1'b0;
      mem_paddr  <= '0;
      stat_flags <= '0;
      abort      <= 1'b0;
      fault      <= 1'b0;
      fault_vpn  <= '0;
    end else begin
      if (byp_we) byp_q <= byp_val;
      mem_strobe <= req_valid & ~stop;
      mem_write  <= req_valid & ~stop & req_write;
      abort      <= req_valid & kill;
      if (req_valid) begin
        mem_paddr  <= xaddr;
        stat_flags <= {f_lk, f_np, f_wp};
      end
      if (req_valid & f_np) begin
        fault <= 1'b1;
        if (!fault || fault_clr) fault_vpn <= vpn;
      end else if (fault_clr) begin
        fault <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pmap_xlate_chk.sv
module pmap_xlate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       fault_clr,
  input logic       byp_q,
  input logic       mem_strobe,
  input logic       mem_write,
  input logic [2:0] stat_flags,
  input logic       abort,
  input logic       fault,
  input logic [6:0] fault_vpn
);
  p_write_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> mem_strobe);

  p_stat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(stat_flags));

  p_abort_nostrobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !mem_strobe);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault);

  p_fault_vpn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> $stable(fault_vpn));

  p_bypass_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_q && req_valid) |=> (stat_flags == 3'b000 && !abort));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_strobe && !abort));
endmodule

bind pmap_xlate pmap_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fault_clr(fault_clr),
  .byp_q(byp_q), .mem_strobe(mem_strobe), .mem_write(mem_write),
  .stat_flags(stat_flags), .abort(abort), .fault(fault), .fault_vpn(fault_vpn)
);

// File: tb/test_pmap_xlate.sv
module test_pmap_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_we = 0, byp_we = 0, byp_val = 0, req_valid = 0, req_write = 0, fault_clr = 0;
  logic [6:0] map_idx = '0;
  logic [11:0] map_wdata = '0;
  logic [15:0] req_vaddr = '0;
  logic mem_strobe, mem_write, abort, fault;
  logic [17:0] mem_paddr;
  logic [2:0] stat_flags;
  logic [6:0] fault_vpn;

  always #5 clk = ~clk;

  pmap_xlate i_pmap_xlate (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx), .map_wdata(map_wdata),
    .byp_we(byp_we), .byp_val(byp_val), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .fault_clr(fault_clr), .mem_strobe(mem_strobe),
    .mem_write(mem_write), .mem_paddr(mem_paddr), .stat_flags(stat_flags),
    .abort(abort), .fault(fault), .fault_vpn(fault_vpn)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [11:0] mdl_map [128];
  bit mdl_byp = 1, mdl_fault = 0;
  logic [6:0] mdl_vpn = '0;
  bit e_stb = 0, e_wr = 0, e_abt = 0;
  logic [17:0] e_pa = '0;
  logic [2:0] e_st = '0;

  function automatic logic [11:0] ent_of(int i);
    logic [2:0] fl;
    case (i)
      3: fl = 3'b001;
      4: fl = 3'b010;
      5: fl = 3'b100;
      6: fl = 3'b011;
      default: fl = 3'b000;
    endcase
    return {fl, 9'((i * 37 + 5) & 'h1ff)};
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit rq, input bit wr, input logic [15:0] va,
                     input bit mwe, input logic [6:0] mi, input logic [11:0] md,
                     input bit bwe, input bit bv, input bit clr, input string tag);
    logic [11:0] e;
    bit wp, np, lk;
    @(negedge clk);
    chk(tag, "mem_strobe", mem_strobe, e_stb);
    chk(tag, "mem_write", mem_write, e_wr);
    chk(tag, "abort", abort, e_abt);
    chk(tag, "stat_flags", stat_flags, e_st);
    chk(tag, "fault", fault, mdl_fault);
    if (mdl_fault) chk(tag, "fault_vpn", fault_vpn, mdl_vpn);
    if (e_stb) chk(tag, "mem_paddr", mem_paddr, e_pa);
    req_valid = rq; req_write = wr; req_vaddr = va;
    map_we = mwe; map_idx = mi; map_wdata = md;
    byp_we = bwe; byp_val = bv; fault_clr = clr;
    e = mdl_map[va[15:9]];
    wp = !mdl_byp && e[9];
    np = !mdl_byp && e[10];
    lk = !mdl_byp && e[11];
    e_stb = rq && !np && !lk && !(wr && wp);
    e_wr  = e_stb && wr;
    e_abt = rq && (lk || (wr && wp));
    if (rq) begin
      e_pa = mdl_byp ? {2'b00, va} : {e[8:0], va[8:0]};
      e_st = {lk, np, wp};
    end
    if (rq && np) begin
      if (!mdl_fault || clr) mdl_vpn = va[15:9];
      mdl_fault = 1;
    end else if (clr) mdl_fault = 0;
    if (mwe) mdl_map[mi] = md;
    if (bwe) mdl_byp = bv;
  endtask

  task automatic rd(input logic [15:0] va, input string tag);
    cyc(1, 0, va, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wt(input logic [15:0] va, input string tag);
    cyc(1, 1, va, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic setbyp(input bit v, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, v, 0, tag);
  endtask
  task automatic clr(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl_map[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle("R1");
    idle("R1");
    // R1/R9: bypass is on after reset, raw address goes out
    rd(16'h1234, "R1");
    wt(16'hfe07, "R9");
    // R3/R8: load the whole map while traffic runs in bypass
    for (int i = 0; i < 128; i++) begin
      cyc(i % 3 == 0, i % 2 == 1, 16'(i * 613), 1, 7'(i), ent_of(i), 0, 0, 0, "R3");
    end
    rd(16'h0800, "R8");
    wt(16'h0a00, "R8");
    rd(16'h0600, "R8");
    setbyp(0, "R9");
    // R2: translation of plain pages
    rd(16'h0000, "R2");
    rd(16'h01ff, "R2");
    wt(16'h0e55, "R2");
    rd(16'hfe3c, "R2");
    wt(16'h4321, "R2");
    idle("R4");
    idle("R4");
    // R5: write-protect page 3
    rd(16'h0612, "R5");
    wt(16'h0612, "R5");
    idle("R10");
    // R6: foreign lock page 5
    rd(16'h0a01, "R6");
    wt(16'h0a02, "R6");
    rd(16'h0a03, "R6");
    // R7: not-present pages 4 and 6
    rd(16'h0811, "R7");
    idle("R7");
    wt(16'h0c00, "R7");
    idle("R7");
    clr("R7");
    idle("R7");
    rd(16'h0c01, "R7");
    cyc(1, 0, 16'h0800, 0, 0, 0, 0, 0, 1, "R7");
    idle("R7");
    clr("R7");
    // R3: load and access the same page in one cycle
    cyc(1, 0, 16'h1400, 1, 7'd10, 12'h0ab, 0, 0, 0, "R3");
    rd(16'h1400, "R3");
    cyc(1, 1, 16'h1402, 1, 7'd10, 12'h9cd, 0, 0, 0, "R3");
    wt(16'h1403, "R3");
    rd(16'h1404, "R3");
    // R8: bypass again, protected pages pass through
    setbyp(1, "R9");
    wt(16'h0612, "R8");
    rd(16'h0a00, "R8");
    wt(16'h0800, "R8");
    idle("R8");
    setbyp(0, "R9");
    wt(16'h0612, "R5");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] | r[1], r[2], r[31:16], r[3] & r[4] & r[5], 7'($urandom), 12'($urandom),
          r[6] & r[7] & r[8] & r[9], r[10] & r[11], r[12] & r[13], "R2");
    end
    idle("R10");
    idle("R10");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule